// File: doc/BRIEF.md
# Branch Target Buffer with Misprediction Repair

This block sits beside the fetch stage of an in-order pipeline. Every cycle the fetch address is looked up in a small direct-mapped table of previously taken branches. The block reports whether the address is a known branch, the predicted direction, the stored target and the branch kind. It also chooses the next fetch address: the stored target when the entry predicts taken, otherwise the sequential address.

When a branch resolves in the execute stage, the pipeline presents the branch address, its real outcome and real target, its fall-through address and the prediction that was made for it at fetch. The block compares the prediction with the outcome. On any disagreement it raises a flush and supplies the address from which fetch must restart. In the same cycle it writes the outcome back into the table. An entry is created only for a branch that resolves taken. An existing entry has its direction counter stepped and, when the branch is taken, its target rewritten.

Both interfaces are plain strobes with no back-pressure: the lookup is purely combinational on `fetch_pc`, and a resolve presented with `rs_valid` high is always consumed at the next clock edge. The flush and repair outputs are combinational on the resolve inputs, so the pipeline can squash its younger latches in the same cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: no lookup hits until a taken branch has been resolved.
- R2: A lookup that misses gives `lk_hit`=0 and `next_pc` = `fetch_pc` + 4, which means predict not-taken.
- R3: A lookup hits when the entry at index `fetch_pc[5:2]` is valid and its stored tag equals `fetch_pc[31:6]`. On a hit, `lk_taken` is the top bit of the entry's 2-bit counter and `lk_target` is the stored target. `next_pc` is `lk_target` when `lk_taken`=1, otherwise `fetch_pc` + 4.
- R4: A resolve that is not taken and misses in the table allocates nothing. A later lookup of that address still misses.
- R5: A resolve that is taken and misses allocates the entry at its index. The entry records the tag, the target and the kind (`lk_uncond`), and its counter is set to weakly-taken (binary 10).
- R6: A resolve that hits steps the counter. It counts up on taken, saturating at 11, and down on not-taken, saturating at 00. It rewrites the target only when the branch is taken, and rewrites the kind in both cases.
- R7: `flush` is 1 for a valid resolve whose predicted direction differs from the actual one, or which was predicted and actually taken with a predicted target different from the actual target.
- R8: While `flush` is 1, `repair_pc` is `rs_target` for a taken branch and `rs_fallthru` for a not-taken branch.
- R9: When a lookup and a resolve touch the same entry in one cycle, the lookup sees the contents from before the write. The write is visible from the next cycle.
- R10: Two addresses with the same index but different tags alias. Allocating one replaces the other, and the replaced address then misses.
- R11: A valid resolve whose direction and (if taken) target match the prediction gives `flush`=0.
- R12: With `rs_valid`=0 the resolve inputs are ignored: `flush`=0 and no entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| lk_hit | output | 1 | Fetch address is a known branch |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_uncond | output | 1 | Stored branch kind (1 = unconditional) |
| lk_target | output | 32 | Stored target of the hit entry |
| next_pc | output | 32 | Chosen next fetch address |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Actual direction |
| rs_uncond | input | 1 | Branch kind (1 = unconditional) |
| rs_target | input | 32 | Actual target |
| rs_fallthru | input | 32 | Sequential address after the branch |
| rs_pred_taken | input | 1 | Direction predicted at fetch |
| rs_pred_target | input | 32 | Target predicted at fetch |
| flush | output | 1 | Misprediction: squash younger work |
| repair_pc | output | 32 | Restart address while flush is high |

## Verification
The fetch lookup and the resolve write-back can land on the same table entry in one cycle. The bench provokes this by driving `fetch_pc` equal to `rs_pc` while a taken resolve allocates a new entry, and again while it replaces the target of an existing entry. In that cycle the lookup must still report the old state (a miss, then the old target). The next lookup of the same address must report the new state, and the flush and repair outputs of the resolve are judged in that same shared cycle. A scoreboard model of the table, built from the requirements, predicts every cycle's outputs.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Kind of write the resolve path requests from the table.
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_UPDATE = 2'd1,
    WR_ALLOC  = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  // fetch read port
  input  logic [IDX_W-1:0] fr_idx,
  output logic             fr_valid,
  output logic [TAG_W-1:0] fr_tag,
  output logic [PC_W-1:0]  fr_target,
  output logic [CTR_W-1:0] fr_ctr,
  output logic             fr_uncond,
  // resolve read port
  input  logic [IDX_W-1:0] rr_idx,
  output logic             rr_valid,
  output logic [TAG_W-1:0] rr_tag,
  output logic [CTR_W-1:0] rr_ctr,
  // write port
  input  wr_kind_e         wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_tgt_en,
  input  logic [PC_W-1:0]  wr_target,
  input  logic [CTR_W-1:0] wr_ctr,
  input  logic             wr_uncond
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic             vld_q    [ENTRIES];
  logic [TAG_W-1:0] tag_q    [ENTRIES];
  logic [PC_W-1:0]  tgt_q    [ENTRIES];
  logic [CTR_W-1:0] ctr_q    [ENTRIES];
  logic             uncond_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = (wr_kind != WR_NONE) && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (sel) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g]    <= wr_tag;
        ctr_q[g]    <= wr_ctr;
        uncond_q[g] <= wr_uncond;
        if (wr_tgt_en) begin
          tgt_q[g] <= wr_target;
        end
      end
    end
  end

  // Reads see the state before this cycle's write.
  assign fr_valid  = vld_q[fr_idx];
  assign fr_tag    = tag_q[fr_idx];
  assign fr_target = tgt_q[fr_idx];
  assign fr_ctr    = ctr_q[fr_idx];
  assign fr_uncond = uncond_q[fr_idx];

  assign rr_valid  = vld_q[rr_idx];
  assign rr_tag    = tag_q[rr_idx];
  assign rr_ctr    = ctr_q[rr_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS_W = 2,
  parameter int unsigned CTR_W = 2
) (
  input  logic [PC_W-1:0]             fetch_pc,
  output logic [IDX_W-1:0]            idx,
  input  logic                        ent_valid,
  input  logic [PC_W-IDX_W-OFS_W-1:0] ent_tag,
  input  logic [PC_W-1:0]             ent_target,
  input  logic [CTR_W-1:0]            ent_ctr,
  input  logic                        ent_uncond,
  output logic                        hit,
  output logic                        taken,
  output logic                        uncond,
  output logic [PC_W-1:0]             target,
  output logic [PC_W-1:0]             next_pc
);

  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1 << OFS_W);

  logic [TAG_W-1:0] tag;
  logic [OFS_W-1:0] lk_unused_ofs;

  assign idx           = fetch_pc[OFS_W +: IDX_W];
  assign tag           = fetch_pc[PC_W-1 -: TAG_W];
  assign lk_unused_ofs = fetch_pc[OFS_W-1:0];

  assign hit     = ent_valid && (ent_tag == tag);
  assign taken   = hit && ent_ctr[CTR_W-1];
  assign uncond  = ent_uncond;
  assign target  = ent_target;
  assign next_pc = taken ? ent_target : (fetch_pc + STEP);

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS_W = 2,
  parameter int unsigned CTR_W = 2
) (
  input  logic                        rs_valid,
  input  logic [PC_W-1:0]             rs_pc,
  input  logic                        rs_taken,
  input  logic                        rs_uncond,
  input  logic [PC_W-1:0]             rs_target,
  input  logic [PC_W-1:0]             rs_fallthru,
  input  logic                        rs_pred_taken,
  input  logic [PC_W-1:0]             rs_pred_target,
  output logic [IDX_W-1:0]            idx,
  input  logic                        ent_valid,
  input  logic [PC_W-IDX_W-OFS_W-1:0] ent_tag,
  input  logic [CTR_W-1:0]            ent_ctr,
  output wr_kind_e                    wr_kind,
  output logic [PC_W-IDX_W-OFS_W-1:0] wr_tag,
  output logic                        wr_tgt_en,
  output logic [PC_W-1:0]             wr_target,
  output logic [CTR_W-1:0]            wr_ctr,
  output logic                        wr_uncond,
  output logic                        flush,
  output logic [PC_W-1:0]             repair_pc
);

  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W;
  localparam logic [CTR_W-1:0] CTR_WEAK = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;

  logic [TAG_W-1:0] tag;
  logic [OFS_W-1:0] rs_unused_ofs;
  logic             hit;
  logic             dir_wrong;
  logic             tgt_wrong;
  logic [CTR_W-1:0] ctr_step;

  assign idx           = rs_pc[OFS_W +: IDX_W];
  assign tag           = rs_pc[PC_W-1 -: TAG_W];
  assign rs_unused_ofs = rs_pc[OFS_W-1:0];
  assign hit           = ent_valid && (ent_tag == tag);

  // Saturating direction counter step.
  always_comb begin
    ctr_step = ent_ctr;
    if (rs_taken) begin
      if (ent_ctr != CTR_MAX) ctr_step = ent_ctr + CTR_W'(1);
    end else begin
      if (ent_ctr != CTR_MIN) ctr_step = ent_ctr - CTR_W'(1);
    end
  end

  // Table write request.
  always_comb begin
    wr_kind = WR_NONE;
    if (rs_valid) begin
      if (hit)           wr_kind = WR_UPDATE;
      else if (rs_taken) wr_kind = WR_ALLOC;
    end
  end

  assign wr_tag    = tag;
  assign wr_tgt_en = rs_taken;
  assign wr_target = rs_target;
  assign wr_uncond = rs_uncond;
  assign wr_ctr    = (wr_kind == WR_ALLOC) ? CTR_WEAK : ctr_step;

  // Misprediction check.
  assign dir_wrong = (rs_pred_taken != rs_taken);
  assign tgt_wrong = rs_taken && rs_pred_taken && (rs_pred_target != rs_target);
  assign flush     = rs_valid && (dir_wrong || tgt_wrong);
  assign repair_pc = rs_taken ? rs_target : rs_fallthru;

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS_W = 2,
  parameter int unsigned CTR_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic            lk_uncond,
  output logic [PC_W-1:0] lk_target,
  output logic [PC_W-1:0] next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_uncond,
  input  logic [PC_W-1:0] rs_target,
  input  logic [PC_W-1:0] rs_fallthru,
  input  logic            rs_pred_taken,
  input  logic [PC_W-1:0] rs_pred_target,
  output logic            flush,
  output logic [PC_W-1:0] repair_pc
);

  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic             f_valid, f_uncond, r_valid;
  logic [TAG_W-1:0] f_tag, r_tag, w_tag;
  logic [PC_W-1:0]  f_target, w_target;
  logic [CTR_W-1:0] f_ctr, r_ctr, w_ctr;
  logic             w_tgt_en, w_uncond;
  wr_kind_e         w_kind;

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .CTR_W(CTR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fr_idx    (f_idx),
    .fr_valid  (f_valid),
    .fr_tag    (f_tag),
    .fr_target (f_target),
    .fr_ctr    (f_ctr),
    .fr_uncond (f_uncond),
    .rr_idx    (r_idx),
    .rr_valid  (r_valid),
    .rr_tag    (r_tag),
    .rr_ctr    (r_ctr),
    .wr_kind   (w_kind),
    .wr_idx    (r_idx),
    .wr_tag    (w_tag),
    .wr_tgt_en (w_tgt_en),
    .wr_target (w_target),
    .wr_ctr    (w_ctr),
    .wr_uncond (w_uncond)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .CTR_W(CTR_W)) u_lookup (
    .fetch_pc   (fetch_pc),
    .idx        (f_idx),
    .ent_valid  (f_valid),
    .ent_tag    (f_tag),
    .ent_target (f_target),
    .ent_ctr    (f_ctr),
    .ent_uncond (f_uncond),
    .hit        (lk_hit),
    .taken      (lk_taken),
    .uncond     (lk_uncond),
    .target     (lk_target),
    .next_pc    (next_pc)
  );

  btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .CTR_W(CTR_W)) u_resolve (
    .rs_valid       (rs_valid),
    .rs_pc          (rs_pc),
    .rs_taken       (rs_taken),
    .rs_uncond      (rs_uncond),
    .rs_target      (rs_target),
    .rs_fallthru    (rs_fallthru),
    .rs_pred_taken  (rs_pred_taken),
    .rs_pred_target (rs_pred_target),
    .idx            (r_idx),
    .ent_valid      (r_valid),
    .ent_tag        (r_tag),
    .ent_ctr        (r_ctr),
    .wr_kind        (w_kind),
    .wr_tag         (w_tag),
    .wr_tgt_en      (w_tgt_en),
    .wr_target      (w_target),
    .wr_ctr         (w_ctr),
    .wr_uncond      (w_uncond),
    .flush          (flush),
    .repair_pc      (repair_pc)
  );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFS_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_target,
  input logic [PC_W-1:0] next_pc,
  input logic            rs_valid,
  input logic [PC_W-1:0] rs_pc,
  input logic            rs_taken,
  input logic [PC_W-1:0] rs_target,
  input logic [PC_W-1:0] rs_fallthru,
  input logic            rs_pred_taken,
  input logic [PC_W-1:0] rs_pred_target,
  input logic            flush,
  input logic [PC_W-1:0] repair_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(1 << OFS_W);

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !lk_hit);

  p_miss_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (next_pc == fetch_pc + STEP));

  p_taken_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_taken) |-> (next_pc == lk_target));

  p_no_alloc_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && !lk_hit && fetch_pc == rs_pc)
      |=> !(lk_hit && fetch_pc == $past(rs_pc)));

  p_taken_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken)
      |=> ((fetch_pc != $past(rs_pc)) || (lk_hit && lk_target == $past(rs_target))));

  p_dir_wrong_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_pred_taken != rs_taken) |-> flush);

  p_repair_fallthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !rs_taken) |-> (repair_pc == rs_fallthru));

  p_correct_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_pred_taken == rs_taken && (!rs_taken || rs_pred_target == rs_target))
      |-> !flush);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !flush);

endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_pc       (fetch_pc),
  .lk_hit         (lk_hit),
  .lk_taken       (lk_taken),
  .lk_target      (lk_target),
  .next_pc        (next_pc),
  .rs_valid       (rs_valid),
  .rs_pc          (rs_pc),
  .rs_taken       (rs_taken),
  .rs_target      (rs_target),
  .rs_fallthru    (rs_fallthru),
  .rs_pred_taken  (rs_pred_taken),
  .rs_pred_target (rs_pred_target),
  .flush          (flush),
  .repair_pc      (repair_pc)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        lk_hit, lk_taken, lk_uncond;
  logic [31:0] lk_target, next_pc;
  logic        rs_valid = 1'b0, rs_taken = 1'b0, rs_uncond = 1'b0, rs_pred_taken = 1'b0;
  logic [31:0] rs_pc = '0, rs_target = '0, rs_fallthru = '0, rs_pred_target = '0;
  logic        flush;
  logic [31:0] repair_pc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  btb_predictor dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_uncond(lk_uncond),
    .lk_target(lk_target), .next_pc(next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_uncond(rs_uncond),
    .rs_target(rs_target), .rs_fallthru(rs_fallthru),
    .rs_pred_taken(rs_pred_taken), .rs_pred_target(rs_pred_target),
    .flush(flush), .repair_pc(repair_pc)
  );

  typedef struct {
    logic        hit, taken, uncond, flush;
    logic [31:0] target, next, repair;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  // Scoreboard model of the table, written from the requirements.
  logic        mv [16];
  logic [25:0] mt [16];
  logic [31:0] mg [16];
  logic [1:0]  mc [16];
  logic        mu [16];

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic step(input logic [31:0] fpc, input logic rv, input logic [31:0] rpc,
                      input logic rt, input logic [31:0] rtgt, input logic ru,
                      input logic rpt, input logic [31:0] rptgt, input string req);
    exp_t e;
    int   fi, ri;
    logic rhit;
    fetch_pc       = fpc;
    rs_valid       = rv;
    rs_pc          = rpc;
    rs_taken       = rt;
    rs_target      = rtgt;
    rs_uncond      = ru;
    rs_fallthru    = rpc + 32'd4;
    rs_pred_taken  = rpt;
    rs_pred_target = rptgt;
    fi       = int'(fpc[5:2]);
    e.hit    = mv[fi] && (mt[fi] == fpc[31:6]);
    e.taken  = e.hit && mc[fi][1];
    e.target = mg[fi];
    e.uncond = mu[fi];
    e.next   = e.taken ? mg[fi] : fpc + 32'd4;
    e.flush  = rv && ((rpt != rt) || (rt && rptgt != rtgt));
    e.repair = rt ? rtgt : rpc + 32'd4;
    e.req    = req;
    exp_q.push_back(e);
    if (rv) begin
      ri   = int'(rpc[5:2]);
      rhit = mv[ri] && (mt[ri] == rpc[31:6]);
      if (rhit) begin
        if (rt) mc[ri] = (mc[ri] == 2'd3) ? 2'd3 : mc[ri] + 2'd1;
        else    mc[ri] = (mc[ri] == 2'd0) ? 2'd0 : mc[ri] - 2'd1;
        if (rt) mg[ri] = rtgt;
        mu[ri] = ru;
      end else if (rt) begin
        mv[ri] = 1'b1;
        mt[ri] = rpc[31:6];
        mg[ri] = rtgt;
        mc[ri] = 2'd2;
        mu[ri] = ru;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] fpc, input string req);
    step(fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, req);
  endtask

  // Monitor: compare outputs mid-cycle against the queued expectation.
  always begin : monitor
    exp_t e;
    @(negedge clk);
    #5;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(lk_hit == e.hit, e.req, "lk_hit", 32'(lk_hit), 32'(e.hit));
      if (e.hit) begin
        chk(lk_taken == e.taken, e.req, "lk_taken", 32'(lk_taken), 32'(e.taken));
        chk(lk_target == e.target, e.req, "lk_target", lk_target, e.target);
        chk(lk_uncond == e.uncond, e.req, "lk_uncond", 32'(lk_uncond), 32'(e.uncond));
      end
      chk(next_pc == e.next, e.req, "next_pc", next_pc, e.next);
      chk(flush == e.flush, e.req, "flush", 32'(flush), 32'(e.flush));
      if (e.flush) chk(repair_pc == e.repair, e.req, "repair_pc", repair_pc, e.repair);
    end
  end

  initial begin : watchdog
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] PA  = 32'h0000_1008;  // index 2
  localparam logic [31:0] PA2 = 32'h0000_1048;  // index 2, other tag
  localparam logic [31:0] PB  = 32'h0000_0020;  // index 8
  localparam logic [31:0] PC  = 32'h0000_0030;  // index 12
  localparam logic [31:0] PX  = 32'h0000_5000;  // index 0, never allocated

  initial begin : driver
    for (int i = 0; i < 16; i++) begin
      mv[i] = 1'b0; mt[i] = '0; mg[i] = '0; mc[i] = '0; mu[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    look(PA, "R1");                                                     // empty after reset
    look(PX, "R2");                                                     // miss -> +4
    step(PA, 1, PA, 0, 32'h0, 0, 0, 32'h0, "R4");                       // nt miss, no alloc
    look(PA, "R4");
    step(PA, 1, PA, 1, 32'h2000, 0, 0, 32'h0, "R9");                    // alloc, same-cycle lookup misses, flush
    look(PA, "R3");                                                     // hit taken -> 0x2000
    step(PX, 1, PA, 0, 32'h0, 0, 1, 32'h2000, "R8");                    // wrong taken -> fallthru repair
    look(PA, "R5");                                                     // weakly-taken became not-taken
    step(PX, 1, PA, 1, 32'h2000, 0, 0, 32'h0, "R7");                    // wrong not-taken
    step(PX, 1, PA, 1, 32'h2000, 0, 1, 32'h2000, "R11");                // correct, quiet
    step(PX, 1, PA, 1, 32'h2000, 0, 1, 32'h2000, "R6");                 // saturate high
    step(PX, 1, PA, 0, 32'h0, 0, 1, 32'h2000, "R6");                    // 3 -> 2
    look(PA, "R6");
    step(PA, 1, PA, 1, 32'h3000, 0, 1, 32'h2000, "R9");                 // wrong target, old read
    look(PA, "R6");                                                     // new target
    look(PA2, "R10");                                                   // alias misses
    step(PA2, 1, PA2, 1, 32'h4000, 0, 0, 32'h0, "R10");                 // replace
    look(PA, "R10");
    look(PA2, "R10");
    step(PX, 1, PA2, 0, 32'h0, 0, 1, 32'h4000, "R6");
    step(PX, 1, PA2, 0, 32'h0, 0, 0, 32'h0, "R6");
    step(PX, 1, PA2, 0, 32'h0, 0, 0, 32'h0, "R6");                      // saturate low
    look(PA2, "R6");
    step(PX, 1, PA2, 1, 32'h4000, 0, 0, 32'h0, "R6");                   // 0 -> 1
    look(PA2, "R6");                                                    // still not-taken
    step(PX, 1, PB, 1, 32'h0000_0040, 1, 0, 32'h0, "R5");               // unconditional alloc
    look(PB, "R5");
    step(PX, 0, PC, 1, 32'h0000_0080, 1, 0, 32'h0, "R12");              // ignored resolve
    look(PC, "R12");

    @(negedge clk);
    #6;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule